// File: doc/BRIEF.md
# Pin Interrupt and Pattern Unit

This block watches eight external input pins and turns their activity into interrupts. Each pin first passes through a two-flop synchronizer. A prior-value register then provides rising and falling edge detection. Each channel has its own enable and a three-bit trigger kind. The kind selects a rising edge, a falling edge, either edge, a high level or a low level.

The unit runs in one of two modes, chosen by a single global bit. In independent mode every enabled channel drives its own interrupt line. Edge-triggered channels hold a sticky flag until software clears that channel alone. Level-triggered channels follow the pin level. In pattern mode the per-channel lines stay low. The enabled channel conditions are then ANDed into one pattern-match interrupt. For a level kind the condition is the current level. For an edge kind it is an edge seen since the last match, remembered in a per-channel sticky bit that each match consumes.

Top module: `pin_event_unit`

## Requirements
- R1: While reset is high and in the cycles after reset with quiet pins, `irq_chan` and `irq_match` are all zero.
- R2: A change on `pins_raw` that is sampled at clock edge k shows up on the outputs after edge k+2. This holds for channel flags, level outputs and the match line alike.
- R3: Kind code 0 (rising edge) sets the channel's `irq_chan` bit on a 0-to-1 pin change. The bit stays set after the pin returns low, until that channel's `clear_req` bit is pulsed.
- R4: Kind code 1 (falling edge) sets the flag only on a 1-to-0 change. A rising change leaves it clear.
- R5: Kind code 2 (both edges) sets the flag on either a rising or a falling change.
- R6: Kind code 3 (high level) drives `irq_chan` high while the synchronized pin is high. A clear pulse has no effect on it, and it drops when the pin goes low.
- R7: Kind code 4 (low level) drives `irq_chan` high while the synchronized pin is low.
- R8: A clear on one channel leaves every other channel's flag unchanged. A clear in the same cycle as a new qualifying edge on that channel leaves the flag set.
- R9: A disabled channel holds `irq_chan` low. Edges that occur while it is disabled are not remembered when it is enabled.
- R10: With `cfg_pattern_mode` high, all `irq_chan` bits are zero. `irq_match` rises when every enabled channel's condition holds at once.
- R11: In pattern mode, an edge on an edge-kind channel is remembered until a match consumes it. A match caused by an edge lasts one cycle.
- R12: `irq_match` stays low in independent mode and when no channel is enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pins_raw | input | 8 | Asynchronous pin inputs |
| cfg_pattern_mode | input | 1 | 1 selects pattern mode, 0 independent mode |
| cfg_enable | input | 8 | Per-channel enable |
| cfg_kind | input | 24 | Trigger kind, 3 bits per channel, channel i at bits 3i+2..3i |
| clear_req | input | 8 | One-cycle per-channel flag clear |
| irq_chan | output | 8 | Per-channel interrupt lines |
| irq_match | output | 1 | Pattern-match interrupt |

## Verification
The bench targets a clear that lands in the same cycle as a fresh edge. A design that gives the clear priority would drop that edge. It checks that a disabled channel forgets edges, because a design that latches while disabled fires a stale interrupt once enabled. In pattern mode it arms an edge term while a level term is false, then satisfies the level later. A design without sticky edges would miss that match, and one that never consumes them would hold the match line high. It also checks that a level channel ignores clears, and that the match line stays silent in independent mode.

// File: rtl/pin_event_pkg.sv
package pin_event_pkg;

    localparam int NUM_PINS    = 8;
    localparam int SYNC_STAGES = 2;
    localparam int KIND_W      = 3;

    typedef enum logic [KIND_W-1:0] {
        TRIG_RISE = 3'd0,
        TRIG_FALL = 3'd1,
        TRIG_BOTH = 3'd2,
        TRIG_HIGH = 3'd3,
        TRIG_LOW  = 3'd4
    } trig_kind_t;

    function automatic logic kind_is_edge(input trig_kind_t k);
        return (k == TRIG_RISE) || (k == TRIG_FALL) || (k == TRIG_BOTH);
    endfunction

    function automatic logic edge_hit(input trig_kind_t k, input logic rise, input logic fall);
        case (k)
            TRIG_RISE: return rise;
            TRIG_FALL: return fall;
            TRIG_BOTH: return rise | fall;
            default:   return 1'b0;
        endcase
    endfunction

    function automatic logic level_hit(input trig_kind_t k, input logic lvl);
        case (k)
            TRIG_HIGH: return lvl;
            TRIG_LOW:  return ~lvl;
            default:   return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/pin_sync_edge.sv
module pin_sync_edge #(
    parameter int WIDTH  = 8,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] pins_async,
    output logic [WIDTH-1:0] lvl,
    output logic [WIDTH-1:0] rise,
    output logic [WIDTH-1:0] fall
);
    logic [WIDTH-1:0] chain [STAGES];
    logic [WIDTH-1:0] prev;

    always_ff @(posedge clk) begin
        if (rst) chain[0] <= '0;
        else     chain[0] <= pins_async;
    end

    for (genvar s = 1; s < STAGES; s++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst) chain[s] <= '0;
            else     chain[s] <= chain[s-1];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) prev <= '0;
        else     prev <= chain[STAGES-1];
    end

    assign lvl  = chain[STAGES-1];
    assign rise = chain[STAGES-1] & ~prev;
    assign fall = ~chain[STAGES-1] & prev;

endmodule

// File: rtl/pin_chan_detect.sv
module pin_chan_detect
    import pin_event_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       pattern_mode,
    input  logic       enable,
    input  trig_kind_t kind,
    input  logic       lvl,
    input  logic       rise,
    input  logic       fall,
    input  logic       clear,
    input  logic       match_now,
    output logic       irq,
    output logic       term
);
    logic edge_kind, edge_now, level_now, sticky;

    always_comb begin
        edge_kind = kind_is_edge(kind);
        edge_now  = edge_hit(kind, rise, fall);
        level_now = level_hit(kind, lvl);
        term      = edge_kind ? (sticky | edge_now) : level_now;
    end

    // independent-mode line: sticky flag for edges, live level otherwise
    always_ff @(posedge clk) begin
        if (rst)                        irq <= 1'b0;
        else if (pattern_mode || !enable) irq <= 1'b0;
        else if (edge_kind)             irq <= edge_now | (irq & ~clear);
        else                            irq <= level_now;
    end

    // pattern-mode edge memory, consumed by a match
    always_ff @(posedge clk) begin
        if (rst)                                      sticky <= 1'b0;
        else if (!pattern_mode || !enable || !edge_kind) sticky <= 1'b0;
        else                                          sticky <= (sticky | edge_now) & ~match_now;
    end

    assert_clear_edge_R8: assert property (@(posedge clk) disable iff (rst)
        (!pattern_mode && enable && edge_kind && clear && !rise && !fall) |=> !irq);

    assert_level_high_R6: assert property (@(posedge clk) disable iff (rst)
        (!pattern_mode && enable && kind == TRIG_HIGH) |=> (irq == $past(lvl)));

    assert_disabled_quiet_R9: assert property (@(posedge clk) disable iff (rst)
        (!enable || pattern_mode) |=> !irq);

endmodule

// File: rtl/pin_pattern_combine.sv
module pin_pattern_combine #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             pattern_mode,
    input  logic [WIDTH-1:0] enable,
    input  logic [WIDTH-1:0] term,
    output logic             match_now,
    output logic             irq_match
);
    assign match_now = pattern_mode && (|enable) && (&(term | ~enable));

    always_ff @(posedge clk) begin
        if (rst) irq_match <= 1'b0;
        else     irq_match <= match_now;
    end

    assert_no_enable_R12: assert property (@(posedge clk) disable iff (rst)
        (enable == '0) |=> !irq_match);

endmodule

// File: rtl/pin_event_unit.sv
module pin_event_unit
    import pin_event_pkg::*;
#(
    parameter int N_CH = NUM_PINS
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [N_CH-1:0]     pins_raw,
    input  logic                cfg_pattern_mode,
    input  logic [N_CH-1:0]     cfg_enable,
    input  logic [N_CH*KIND_W-1:0] cfg_kind,
    input  logic [N_CH-1:0]     clear_req,
    output logic [N_CH-1:0]     irq_chan,
    output logic                irq_match
);
    logic [N_CH-1:0] lvl, rise, fall, term;
    logic            match_now;

    pin_sync_edge #(.WIDTH(N_CH), .STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst(rst), .pins_async(pins_raw),
        .lvl(lvl), .rise(rise), .fall(fall)
    );

    for (genvar i = 0; i < N_CH; i++) begin : g_ch
        pin_chan_detect u_ch (
            .clk(clk), .rst(rst),
            .pattern_mode(cfg_pattern_mode),
            .enable(cfg_enable[i]),
            .kind(trig_kind_t'(cfg_kind[i*KIND_W +: KIND_W])),
            .lvl(lvl[i]), .rise(rise[i]), .fall(fall[i]),
            .clear(clear_req[i]),
            .match_now(match_now),
            .irq(irq_chan[i]),
            .term(term[i])
        );
    end

    pin_pattern_combine #(.WIDTH(N_CH)) u_pat (
        .clk(clk), .rst(rst),
        .pattern_mode(cfg_pattern_mode),
        .enable(cfg_enable), .term(term),
        .match_now(match_now), .irq_match(irq_match)
    );

    assert_indep_no_match_R12: assert property (@(posedge clk) disable iff (rst)
        !cfg_pattern_mode |=> !irq_match);

    assert_mode_exclusive_R10: assert property (@(posedge clk) disable iff (rst)
        irq_match |-> (irq_chan == '0));

endmodule

// File: tb/pin_event_unit_tb.sv
module pin_event_unit_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [7:0]  pins = 8'h20;
    logic        mode = 1'b0;
    logic [7:0]  en = 8'hBF;
    logic [23:0] kind = {3'd0, 3'd0, 3'd4, 3'd3, 3'd2, 3'd1, 3'd0, 3'd0};
    logic [7:0]  clr = 8'h00;
    logic [7:0]  irq_chan;
    logic        irq_match;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    bit done = 0;

    int         qc[$];
    logic [8:0] qv[$];
    string      qt[$];

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    pin_event_unit u_dut (
        .clk(clk), .rst(rst), .pins_raw(pins),
        .cfg_pattern_mode(mode), .cfg_enable(en), .cfg_kind(kind),
        .clear_req(clr), .irq_chan(irq_chan), .irq_match(irq_match)
    );

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic expect_in(input int n, input logic [7:0] ch, input logic m, input string tag);
        qc.push_back(cyc + n);
        qv.push_back({ch, m});
        qt.push_back(tag);
    endtask

    task automatic drive(input logic [7:0] p, input logic [7:0] ch, input logic m, input string tag);
        pins = p;
        expect_in(3, ch, m, tag);
        tick(3);
    endtask

    task automatic pulse_clear(input logic [7:0] c, input logic [7:0] ch, input string tag);
        clr = c;
        expect_in(1, ch, 1'b0, tag);
        tick(1);
        clr = 8'h00;
    endtask

    // scoreboard monitor
    always @(negedge clk) begin
        while (qc.size() > 0 && qc[0] <= cyc) begin
            logic [8:0] e;
            string t;
            int c;
            c = qc.pop_front();
            e = qv.pop_front();
            t = qt.pop_front();
            checks++;
            if (c != cyc || {irq_chan, irq_match} !== e) begin
                errors++;
                $display("FAIL %s: cycle %0d chan=%h match=%b expected chan=%h match=%b",
                         t, cyc, irq_chan, irq_match, e[8:1], e[0]);
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: run did not complete");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        tick(1);
        expect_in(1, 8'h00, 1'b0, "R1");
        tick(3);
        rst = 1'b0;
        expect_in(3, 8'h00, 1'b0, "R1");
        tick(3);

        // R2/R3 rising, sticky after pin drops
        drive(8'h21, 8'h01, 1'b0, "R2");
        drive(8'h20, 8'h01, 1'b0, "R3");
        drive(8'h22, 8'h03, 1'b0, "R3");
        pulse_clear(8'h01, 8'h02, "R8");
        tick(1);
        pulse_clear(8'h02, 8'h00, "R3");
        tick(1);
        drive(8'h20, 8'h00, 1'b0, "R3");
        // clear coinciding with a new edge: set wins (R8)
        pins = 8'h22;
        tick(2);
        clr = 8'h02;
        tick(1);
        clr = 8'h00;
        expect_in(0, 8'h02, 1'b0, "R8");
        tick(1);
        pulse_clear(8'h02, 8'h00, "R8");
        tick(1);

        // R4 falling
        drive(8'h24, 8'h00, 1'b0, "R4");
        drive(8'h20, 8'h04, 1'b0, "R4");
        pulse_clear(8'h04, 8'h00, "R4");
        tick(1);

        // R5 both edges
        drive(8'h28, 8'h08, 1'b0, "R5");
        pulse_clear(8'h08, 8'h00, "R5");
        tick(1);
        drive(8'h20, 8'h08, 1'b0, "R5");
        pulse_clear(8'h08, 8'h00, "R5");
        tick(1);

        // R6 high level ignores clear
        drive(8'h30, 8'h10, 1'b0, "R6");
        pulse_clear(8'h10, 8'h10, "R6");
        tick(1);
        drive(8'h20, 8'h00, 1'b0, "R6");

        // R7 low level
        drive(8'h00, 8'h20, 1'b0, "R7");
        drive(8'h20, 8'h00, 1'b0, "R7");

        // R9 disabled channel forgets edges
        drive(8'h60, 8'h00, 1'b0, "R9");
        en = 8'hFF;
        expect_in(2, 8'h00, 1'b0, "R9");
        tick(2);
        drive(8'h20, 8'h00, 1'b0, "R9");
        drive(8'h60, 8'h40, 1'b0, "R9");
        pulse_clear(8'h40, 8'h00, "R9");
        tick(1);

        // pattern mode: ch0 rising edge AND ch4 high
        mode = 1'b1;
        en = 8'h11;
        expect_in(1, 8'h00, 1'b0, "R10");
        tick(2);
        drive(8'h70, 8'h00, 1'b0, "R10");
        pins = 8'h71;
        expect_in(3, 8'h00, 1'b1, "R10");
        expect_in(4, 8'h00, 1'b0, "R11");
        tick(4);
        drive(8'h61, 8'h00, 1'b0, "R11");
        drive(8'h60, 8'h00, 1'b0, "R11");
        drive(8'h61, 8'h00, 1'b0, "R11");
        pins = 8'h71;
        expect_in(3, 8'h00, 1'b1, "R11");
        expect_in(4, 8'h00, 1'b0, "R11");
        tick(4);
        expect_in(2, 8'h00, 1'b0, "R11");
        tick(2);

        // R12 no enables, then independent mode
        en = 8'h00;
        drive(8'h60, 8'h00, 1'b0, "R12");
        drive(8'h71, 8'h00, 1'b0, "R12");
        mode = 1'b0;
        en = 8'h01;
        expect_in(2, 8'h00, 1'b0, "R12");
        tick(2);
        drive(8'h70, 8'h00, 1'b0, "R12");
        drive(8'h71, 8'h01, 1'b0, "R12");
        tick(2);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule